// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block is the flag-producing slice of an integer execution unit. It takes two 32-bit operands, an operation select, an operand-size select and a carry input. It returns the result of an add, subtract or bitwise logical operation at 8, 16 or 32 bits. From that same result it derives six status bits: carry, overflow, sign, zero, auxiliary (nibble) carry and parity.

The result is combinational. Operand bits above the selected width are ignored, and result bits above the width read as zero. The six status bits are captured in a flag register on a rising clock edge, but only in cycles where the write enable is high. The registered copy is what the block presents on its flag outputs.

Arithmetic flags are width-aware. Carry and overflow are judged against the selected width, sign is the top bit at that width, and zero tests only the selected width. Nibble carry always looks at the boundary between bit 3 and bit 4. Parity always looks at the lowest byte.

Top module: `flag_alu`

## Requirements
- R1: `op_sel` encodings are 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 AND, 5 OR and 6 XOR; code 7 behaves as AND. `size_sel` encodings are 0 for 8-bit, 1 for 16-bit and 2 for 32-bit; code 3 behaves as 32-bit. Operand bits above the width are ignored, and `result` bits above the width are zero.
- R2: For add operations, carry is set when the unsigned sum does not fit in the selected width. For subtract operations, carry is set when a borrow occurs, that is, when the unsigned minuend is smaller than the subtrahend plus the borrow-in.
- R3: Overflow is set when the signed (two's complement) outcome at the selected width lies outside that width's signed range.
- R4: Sign equals the most significant result bit at the selected width.
- R5: Zero is set exactly when the result at the selected width is all zeros.
- R6: Auxiliary carry is set on a carry from bit 3 into bit 4 for additions, and on a borrow from bit 4 into bit 3 for subtractions.
- R7: Parity is set when result bits 7:0 hold an even number of ones.
- R8: Logical operations (codes 4 to 7) clear carry, overflow and auxiliary carry.
- R9: The flag register loads all six flags on a rising edge where `flag_we` is high. When `flag_we` is low, it keeps its previous value; `result` still follows the inputs.
- R10: A synchronous active-high `rst` clears all six registered flags.
- R11: `carry_in` enters only codes 1 and 3. It has no effect on add, subtract or the logical operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| opnd_a | input | 32 | First operand (minuend for subtract) |
| opnd_b | input | 32 | Second operand (subtrahend for subtract) |
| op_sel | input | 3 | Operation code, see R1 |
| size_sel | input | 2 | Operand width code, see R1 |
| carry_in | input | 1 | Carry or borrow input for codes 1 and 3 |
| flag_we | input | 1 | Flag register write enable |
| result | output | 32 | Combinational result, zero above the width |
| flag_cf | output | 1 | Registered carry / borrow |
| flag_of | output | 1 | Registered signed overflow |
| flag_sf | output | 1 | Registered sign |
| flag_zf | output | 1 | Registered zero |
| flag_af | output | 1 | Registered nibble carry / borrow |
| flag_pf | output | 1 | Registered low-byte even parity |

## Verification
The in-RTL assertions check the following on every cycle:
- the result bits above the selected width stay zero;
- logical operations produce clear carry, overflow and nibble-carry bits;
- the flag register holds while writes are disabled;
- zero and parity, after a write, match the result that was present at the write.

Only the bench scenarios can show the rest:
- that carry, borrow and signed overflow are judged at the right width;
- that the nibble boundary behaves correctly for both add and subtract;
- that `carry_in` is ignored outside add-with-carry and subtract-with-borrow;
- that reset clears flags that were previously set.

The bench checks these against an arithmetic model that works on wide integers rather than on bit slices.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

    localparam int DATA_W = 32;
    localparam int OP_W   = 3;
    localparam int SIZE_W = 2;
    localparam int NIB_W  = 4;
    localparam int BYTE_W = 8;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBB = 3'd3,
        OP_AND = 3'd4,
        OP_OR  = 3'd5,
        OP_XOR = 3'd6,
        OP_RSV = 3'd7
    } op_e;

    typedef enum logic [SIZE_W-1:0] {
        SZ_8   = 2'd0,
        SZ_16  = 2'd1,
        SZ_32  = 2'd2,
        SZ_RSV = 2'd3
    } size_e;

    typedef struct packed {
        logic cf;
        logic of;
        logic sf;
        logic zf;
        logic af;
        logic pf;
    } flags_t;

    function automatic int unsigned width_of(size_e s);
        case (s)
            SZ_8:    return 8;
            SZ_16:   return 16;
            default: return DATA_W;
        endcase
    endfunction

    function automatic int unsigned top_bit(size_e s);
        return width_of(s) - 1;
    endfunction

    function automatic logic [DATA_W-1:0] width_mask(size_e s);
        return {DATA_W{1'b1}} >> (DATA_W - width_of(s));
    endfunction

    function automatic logic is_arith(op_e op);
        return (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB) || (op == OP_SBB);
    endfunction

    function automatic logic is_sub(op_e op);
        return (op == OP_SUB) || (op == OP_SBB);
    endfunction

    function automatic logic uses_cin(op_e op);
        return (op == OP_ADC) || (op == OP_SBB);
    endfunction

endpackage

// File: rtl/alu_arith.sv
module alu_arith
    import alu_flag_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  op_e          op,
    input  size_e        size,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout,
    output logic         ovf,
    output logic         nib_c
);
    logic [W-1:0] mask;
    logic [W-1:0] am;
    logic [W-1:0] bm;
    logic [W:0]   full;
    logic [W:0]   c_ext;
    int unsigned  msb;
    logic         sa;
    logic         sb;
    logic         sr;

    always_comb begin
        mask  = width_mask(size);
        msb   = top_bit(size);
        am    = a & mask;
        bm    = b & mask;
        c_ext = {{W{1'b0}}, uses_cin(op) & cin};
        if (is_sub(op))
            full = {1'b0, am} - {1'b0, bm} - c_ext;
        else
            full = {1'b0, am} + {1'b0, bm} + c_ext;
        res   = full[W-1:0] & mask;
        cout  = full[msb+1];
        sa    = am[msb];
        sb    = bm[msb];
        sr    = res[msb];
        if (is_sub(op))
            ovf = (sa != sb) && (sr != sa);
        else
            ovf = (sa == sb) && (sr != sa);
        nib_c = am[NIB_W] ^ bm[NIB_W] ^ res[NIB_W];
    end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_flag_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  op_e          op,
    input  logic [W-1:0] mask,
    output logic [W-1:0] res
);
    logic [W-1:0] raw;

    always_comb begin
        case (op)
            OP_OR:   raw = a | b;
            OP_XOR:  raw = a ^ b;
            default: raw = a & b;
        endcase
        res = raw & mask;
    end

endmodule

// File: rtl/alu_flag_calc.sv
module alu_flag_calc
    import alu_flag_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  op_e          op,
    input  size_e        size,
    input  logic [W-1:0] arith_res,
    input  logic         arith_cout,
    input  logic         arith_ovf,
    input  logic         arith_nib,
    input  logic [W-1:0] logic_res,
    output logic [W-1:0] res,
    output flags_t       flags
);
    logic arith;

    always_comb begin
        arith    = is_arith(op);
        res      = arith ? arith_res : logic_res;
        flags.cf = arith & arith_cout;
        flags.of = arith & arith_ovf;
        flags.af = arith & arith_nib;
        flags.sf = res[top_bit(size)];
        flags.zf = (res == '0);
        flags.pf = ~^res[BYTE_W-1:0];
    end

endmodule

// File: rtl/flag_reg.sv
module flag_reg
    import alu_flag_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   we,
    input  flags_t d,
    output flags_t q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (we)
            q <= d;
    end

    // R9: no write enable, no change
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));

    // R9: a write captures the computed flags
    p_load_r9: assert property (@(posedge clk) disable iff (rst)
        we |=> (q == $past(d)));

endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import alu_flag_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic [2:0]   op_sel,
    input  logic [1:0]   size_sel,
    input  logic         carry_in,
    input  logic         flag_we,
    output logic [W-1:0] result,
    output logic         flag_cf,
    output logic         flag_of,
    output logic         flag_sf,
    output logic         flag_zf,
    output logic         flag_af,
    output logic         flag_pf
);
    op_e          op;
    size_e        size;
    logic [W-1:0] mask;
    logic [W-1:0] a_res;
    logic [W-1:0] l_res;
    logic         a_cout;
    logic         a_ovf;
    logic         a_nib;
    flags_t       fl_d;
    flags_t       fl_q;

    assign op   = op_e'(op_sel);
    assign size = size_e'(size_sel);
    assign mask = width_mask(size);

    alu_arith #(.W(W)) u_arith (
        .a     (opnd_a),
        .b     (opnd_b),
        .op    (op),
        .size  (size),
        .cin   (carry_in),
        .res   (a_res),
        .cout  (a_cout),
        .ovf   (a_ovf),
        .nib_c (a_nib)
    );

    alu_logic #(.W(W)) u_logic (
        .a    (opnd_a),
        .b    (opnd_b),
        .op   (op),
        .mask (mask),
        .res  (l_res)
    );

    alu_flag_calc #(.W(W)) u_calc (
        .op         (op),
        .size       (size),
        .arith_res  (a_res),
        .arith_cout (a_cout),
        .arith_ovf  (a_ovf),
        .arith_nib  (a_nib),
        .logic_res  (l_res),
        .res        (result),
        .flags      (fl_d)
    );

    flag_reg u_freg (
        .clk (clk),
        .rst (rst),
        .we  (flag_we),
        .d   (fl_d),
        .q   (fl_q)
    );

    assign flag_cf = fl_q.cf;
    assign flag_of = fl_q.of;
    assign flag_sf = fl_q.sf;
    assign flag_zf = fl_q.zf;
    assign flag_af = fl_q.af;
    assign flag_pf = fl_q.pf;

    // R1: nothing leaks above the selected width
    p_upper_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (result & ~mask) == '0);

    // R8: logical codes leave carry, overflow and nibble carry clear
    p_logic_clear_r8: assert property (@(posedge clk) disable iff (rst)
        !is_arith(op) |-> (!fl_d.cf && !fl_d.of && !fl_d.af));

    // R5: registered zero reflects the result present at the write
    p_zero_r5: assert property (@(posedge clk) disable iff (rst)
        flag_we |=> (flag_zf == ($past(result) == '0)));

    // R7: registered parity reflects the low byte present at the write
    p_parity_r7: assert property (@(posedge clk) disable iff (rst)
        flag_we |=> (flag_pf == ~^$past(result[BYTE_W-1:0])));

endmodule

// File: tb/test_flag_alu.sv
`timescale 1ns/1ps
module test_flag_alu;

    typedef struct {
        string       req;
        logic [31:0] res;
        logic [5:0]  fl;
    } item_t;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] opnd_a;
    logic [31:0] opnd_b;
    logic [2:0]  op_sel;
    logic [1:0]  size_sel;
    logic        carry_in;
    logic        flag_we;
    logic [31:0] result;
    logic        flag_cf, flag_of, flag_sf, flag_zf, flag_af, flag_pf;

    item_t       sb_q[$];
    int          n_checks = 0;
    int          n_fail   = 0;
    logic [5:0]  ref_fl   = '0;
    logic [31:0] lfsr     = 32'h1ACE_B00C;
    bit          done     = 0;

    always #2.5 clk = ~clk;

    flag_alu i_flag_alu (
        .clk(clk), .rst(rst), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .op_sel(op_sel), .size_sel(size_sel), .carry_in(carry_in),
        .flag_we(flag_we), .result(result),
        .flag_cf(flag_cf), .flag_of(flag_of), .flag_sf(flag_sf),
        .flag_zf(flag_zf), .flag_af(flag_af), .flag_pf(flag_pf)
    );

    // flag vector order: {cf, of, sf, zf, af, pf}
    function automatic void model(input logic [2:0] op, input logic [1:0] sz,
                                  input logic [31:0] a, input logic [31:0] b,
                                  input logic cin, output logic [31:0] r,
                                  output logic [5:0] fl);
        longint unsigned w, lim, m, am, bm, c, s;
        longint          sa, sb, sr, half;
        logic cf, of, sf, zf, af, pf;
        w    = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        lim  = 64'd1 << w;
        m    = lim - 1;
        half = longint'(lim / 2);
        am   = {32'd0, a} & m;
        bm   = {32'd0, b} & m;
        c    = (op == 3'd1 || op == 3'd3) ? {63'd0, cin} : 64'd0;
        sa   = (longint'(am) >= half) ? longint'(am) - longint'(lim) : longint'(am);
        sb   = (longint'(bm) >= half) ? longint'(bm) - longint'(lim) : longint'(bm);
        cf = 0; of = 0; af = 0;
        case (op)
            3'd0, 3'd1: begin
                s  = am + bm + c;
                r  = 32'(s & m);
                cf = (s >= lim);
                af = ((am & 15) + (bm & 15) + c) > 15;
                sr = sa + sb + longint'(c);
                of = (sr >= half) || (sr < -half);
            end
            3'd2, 3'd3: begin
                s  = am - bm - c;
                r  = 32'(s & m);
                cf = am < (bm + c);
                af = (am & 15) < ((bm & 15) + c);
                sr = sa - sb - longint'(c);
                of = (sr >= half) || (sr < -half);
            end
            3'd5:    r = 32'((am | bm) & m);
            3'd6:    r = 32'((am ^ bm) & m);
            default: r = 32'((am & bm) & m);
        endcase
        sf = r[w-1];
        zf = (r == 32'd0);
        pf = ~^r[7:0];
        fl = {cf, of, sf, zf, af, pf};
    endfunction

    task automatic do_op(input logic [2:0] op, input logic [1:0] sz,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic cin, input logic we, input string req);
        logic [31:0] r;
        logic [5:0]  fl;
        item_t       it;
        @(negedge clk);
        op_sel = op; size_sel = sz; opnd_a = a; opnd_b = b;
        carry_in = cin; flag_we = we;
        model(op, sz, a, b, cin, r, fl);
        if (we) ref_fl = fl;
        it.req = req; it.res = r; it.fl = ref_fl;
        sb_q.push_back(it);
    endtask

    task automatic check_direct(input string req, input logic [37:0] act,
                                input logic [37:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: scoreboard compare after each registering edge
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                check_direct(it.req,
                    {result, flag_cf, flag_of, flag_sf, flag_zf, flag_af, flag_pf},
                    {it.res, it.fl});
            end
        end
    end

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1; flag_we = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        ref_fl = '0;
        check_direct("R10",
            {32'd0, flag_cf, flag_of, flag_sf, flag_zf, flag_af, flag_pf}, 38'd0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; opnd_a = '0; opnd_b = '0; op_sel = '0; size_sel = '0;
        carry_in = 1'b0; flag_we = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: flags clear out of reset
        check_direct("R10",
            {32'd0, flag_cf, flag_of, flag_sf, flag_zf, flag_af, flag_pf}, 38'd0);

        // R2 R5 R6 R7: 8-bit wrap to zero
        do_op(3'd0, 2'd0, 32'h0000_00FF, 32'h0000_0001, 1'b0, 1'b1, "R2");
        // R3 R4: 8-bit signed overflow into negative
        do_op(3'd0, 2'd0, 32'h0000_007F, 32'h0000_0001, 1'b0, 1'b1, "R3");
        // R2: 16-bit carry out
        do_op(3'd0, 2'd1, 32'h0000_FFFF, 32'h0000_0003, 1'b0, 1'b1, "R2");
        // R3: 32-bit signed overflow
        do_op(3'd0, 2'd2, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 1'b1, "R3");
        // R1: upper operand bits ignored at 8 bits
        do_op(3'd0, 2'd0, 32'h1234_56F0, 32'hABCD_0020, 1'b0, 1'b1, "R1");
        // R1: size code 3 acts as 32-bit
        do_op(3'd0, 2'd3, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b1, "R1");
        // R2 R6: 8-bit borrow
        do_op(3'd2, 2'd0, 32'h0000_0000, 32'h0000_0001, 1'b0, 1'b1, "R2");
        // R3: 8-bit subtract overflow
        do_op(3'd2, 2'd0, 32'h0000_0080, 32'h0000_0001, 1'b0, 1'b1, "R3");
        // R6: nibble borrow only, 16-bit
        do_op(3'd2, 2'd1, 32'h0000_0110, 32'h0000_0001, 1'b0, 1'b1, "R6");
        // R4: 16-bit sign
        do_op(3'd2, 2'd1, 32'h0000_0001, 32'h0000_0002, 1'b0, 1'b1, "R4");
        // R11: add-with-carry and subtract-with-borrow use carry_in
        do_op(3'd1, 2'd0, 32'h0000_000F, 32'h0000_0000, 1'b1, 1'b1, "R11");
        do_op(3'd3, 2'd1, 32'h0000_0000, 32'h0000_0000, 1'b1, 1'b1, "R11");
        // R11: carry_in ignored by plain add, subtract and logic
        do_op(3'd0, 2'd0, 32'h0000_00FF, 32'h0000_0000, 1'b1, 1'b1, "R11");
        do_op(3'd2, 2'd0, 32'h0000_0000, 32'h0000_0000, 1'b1, 1'b1, "R11");
        do_op(3'd6, 2'd0, 32'h0000_0000, 32'h0000_0000, 1'b1, 1'b1, "R11");
        // R8: logic after a carry-setting op
        do_op(3'd0, 2'd0, 32'h0000_00FF, 32'h0000_00FF, 1'b0, 1'b1, "R2");
        do_op(3'd4, 2'd0, 32'h0000_00F0, 32'h0000_00FF, 1'b0, 1'b1, "R8");
        do_op(3'd5, 2'd1, 32'h0000_8000, 32'h0000_0001, 1'b0, 1'b1, "R8");
        do_op(3'd6, 2'd2, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 1'b0, 1'b1, "R8");
        do_op(3'd7, 2'd2, 32'hF0F0_F0F0, 32'hFF00_FF00, 1'b0, 1'b1, "R1");
        // R7: odd parity in low byte, upper bits set
        do_op(3'd5, 2'd2, 32'hFF00_0000, 32'h0000_0001, 1'b0, 1'b1, "R7");
        // R9: writes disabled, flags hold while result moves
        do_op(3'd0, 2'd0, 32'h0000_00FF, 32'h0000_0001, 1'b0, 1'b1, "R9");
        do_op(3'd5, 2'd0, 32'h0000_0012, 32'h0000_0000, 1'b0, 1'b0, "R9");
        do_op(3'd2, 2'd2, 32'h0000_0005, 32'h0000_0009, 1'b0, 1'b0, "R9");
        do_op(3'd4, 2'd1, 32'h0000_0003, 32'h0000_0001, 1'b0, 1'b1, "R9");
        // R10: reset clears flags that were set
        do_op(3'd2, 2'd0, 32'h0000_0000, 32'h0000_0001, 1'b0, 1'b1, "R2");
        apply_reset();
        // R5: zero tested at width only
        do_op(3'd2, 2'd1, 32'h0001_1234, 32'h0002_1234, 1'b0, 1'b1, "R5");
        // pseudo-random sweep across all codes and widths
        for (int i = 0; i < 80; i++) begin
            logic [31:0] ra;
            logic [31:0] rb;
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            ra = lfsr;
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            rb = lfsr;
            do_op(ra[2:0], ra[4:3], ra, rb, rb[0], ra[9] | ra[10], "R3");
        end
        while (sb_q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule